// File: doc/BRIEF.md
# Register-Exchange Survivor Path Unit

This block holds the survivor paths of a four-state Viterbi decoder for a constraint-length-3 code and keeps them in register-exchange form. Every state owns a shift register that always contains the decoded bits along that state's best path so far. On each trellis step an external add-compare-select stage supplies one decision bit per state and the index of the state with the best path metric. Each state register then takes a copy of the register of the predecessor that its decision selects, and appends the input bit that leads into that state.

Since every register is always in decoded order, the output needs no backward search and no bit reversal. After eight accepted steps the block emits the register of the chosen best state as one eight-bit decoded word, together with a one-cycle strobe. A frame-start pulse clears every survivor and restarts the step count.

Top module: `re_survivor_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `word_valid` is 0 and `word_out` is all zeros.
- R2: A `frame_start` pulse clears all four survivor registers to zero and restarts the step count, so a word appears only after eight further accepted steps.
- R3: State s is encoded as {newest input bit, previous input bit}. On an accepted step, the survivor of s becomes the old survivor of predecessor {s[0], decision[s]} shifted up by one bit, with s[1] placed in bit 0. The oldest bit falls off.
- R4: In an emitted word, bit 7 holds the bit appended at the first step of the frame and bit 0 holds the bit appended at the eighth step.
- R5: In the cycle after the eighth accepted step, `word_valid` is 1 for exactly one cycle. `word_out` then equals the updated survivor of the state that `best_state` named at that eighth step.
- R6: When `step_valid` is 0, `decisions` and `best_state` have no effect. Survivors and the step count keep their values.
- R7: When `frame_start` and `step_valid` are both 1 in the same cycle, the step is discarded and the clear takes effect.
- R8: `word_out` keeps its last value in every cycle in which `word_valid` is 0.
- R9: Without a new `frame_start`, steps that follow a completed word start the next eight-step count. The survivors carry on shifting from their current contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Clears survivors and step count |
| step_valid | input | 1 | Marks the trellis step of this cycle as accepted |
| decisions | input | 4 | One predecessor-select bit per state, bit index = state |
| best_state | input | 2 | State with the best path metric in this step |
| word_valid | output | 1 | One-cycle strobe for a decoded word |
| word_out | output | 8 | Decoded word, first decoded bit in bit 7 |

## Verification
Every result is registered once. The survivors and the word strobe change at the clock edge that accepts a step, so they are visible one cycle after the stimulus. A step's inputs can therefore affect `word_out` only at the following sampling point. The bench drives inputs at the falling edge and advances a behavioural reference on the rising edge. It compares `word_valid` and `word_out` at the next falling edge, so the expected value always belongs to the cycle in which it is due. Idle gaps, mid-frame restarts and back-to-back frames move the strobe cycle, and the per-cycle comparison catches a strobe that comes one cycle early or late.

// File: rtl/re_surv_pkg.sv
package re_surv_pkg;

   // Predecessor of state s: shift the history down one position and place
   // the decision bit as the oldest bit ({s[0], d} for a four-state trellis).
   function automatic int unsigned pred_of(input int unsigned s,
                                           input int unsigned d,
                                           input int unsigned nstates);
      return ((s << 1) | (d & 1)) & (nstates - 1);
   endfunction

   // Bit appended when entering state s: its newest-input field.
   function automatic logic entry_bit(input int unsigned s,
                                      input int unsigned sw);
      return logic'((s >> (sw - 1)) & 1);
   endfunction

endpackage

// File: rtl/re_survivor_cell.sv
module re_survivor_cell #(
   parameter int unsigned STATE_ID   = 0,
   parameter int unsigned STATE_BITS = 2,
   parameter int unsigned WIDTH      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             dec,
   input  logic [WIDTH-1:0] cand0,
   input  logic [WIDTH-1:0] cand1,
   output logic [WIDTH-1:0] surv_q,
   output logic [WIDTH-1:0] surv_next
);
   import re_surv_pkg::*;

   localparam logic NEW_BIT = entry_bit(STATE_ID, STATE_BITS);

   logic [WIDTH-1:0] chosen;

   always_comb begin
      chosen = dec ? cand1 : cand0;
   end

   generate
      if (WIDTH == 1) begin : g_narrow
         always_comb surv_next = NEW_BIT;
      end else begin : g_wide
         always_comb surv_next = {chosen[WIDTH-2:0], NEW_BIT};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         surv_q <= '0;
      end else if (clear) begin
         surv_q <= '0;
      end else if (step) begin
         surv_q <= surv_next;
      end
   end

endmodule

// File: rtl/re_step_counter.sv
module re_step_counter #(
   parameter int unsigned FRAME_BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);
   localparam int unsigned CW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);
   localparam bit POW2 = (FRAME_BITS == (1 << CW));

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;

   always_comb last = (cnt_q == LAST_IDX);

   generate
      if (POW2) begin : g_wrap_free
         always_comb cnt_inc = cnt_q + CW'(1);
      end else begin : g_wrap_cmp
         always_comb cnt_inc = last ? '0 : cnt_q + CW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_inc;
      end
   end

endmodule

// File: rtl/re_word_select.sv
module re_word_select #(
   parameter int unsigned NUM_STATES = 4,
   parameter int unsigned STATE_BITS = 2,
   parameter int unsigned WIDTH      = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 emit,
   input  logic [STATE_BITS-1:0]                best,
   input  logic [NUM_STATES-1:0][WIDTH-1:0]     surv_next,
   output logic                                 word_valid,
   output logic [WIDTH-1:0]                     word_out
);
   logic [WIDTH-1:0] picked;

   always_comb picked = surv_next[best];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_valid <= 1'b0;
         word_out   <= '0;
      end else begin
         word_valid <= emit;
         if (emit) begin
            word_out <= picked;
         end
      end
   end

endmodule

// File: rtl/re_survivor_unit.sv
module re_survivor_unit #(
   parameter int unsigned CONSTRAINT_LEN = 3,
   parameter int unsigned FRAME_BITS     = 8,
   localparam int unsigned STATE_BITS    = CONSTRAINT_LEN - 1,
   localparam int unsigned NUM_STATES    = 1 << STATE_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  logic                  step_valid,
   input  logic [NUM_STATES-1:0] decisions,
   input  logic [STATE_BITS-1:0] best_state,
   output logic                  word_valid,
   output logic [FRAME_BITS-1:0] word_out
);
   import re_surv_pkg::*;

   generate
      if (CONSTRAINT_LEN < 2 || CONSTRAINT_LEN > 9) begin : g_bad_k
         $error("re_survivor_unit: CONSTRAINT_LEN must be 2..9");
      end
      if (FRAME_BITS < 2 || FRAME_BITS > 64) begin : g_bad_frame
         $error("re_survivor_unit: FRAME_BITS must be 2..64");
      end
   endgenerate

   logic take_step;
   logic at_last;
   logic emit;
   logic [NUM_STATES-1:0][FRAME_BITS-1:0] surv_q;
   logic [NUM_STATES-1:0][FRAME_BITS-1:0] surv_next;

   always_comb begin
      take_step = step_valid && !frame_start;
      emit      = take_step && at_last;
   end

   genvar gs;
   generate
      for (gs = 0; gs < NUM_STATES; gs++) begin : g_state
         localparam int unsigned P0 = pred_of(gs, 0, NUM_STATES);
         localparam int unsigned P1 = pred_of(gs, 1, NUM_STATES);
         re_survivor_cell #(
            .STATE_ID  (gs),
            .STATE_BITS(STATE_BITS),
            .WIDTH     (FRAME_BITS)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (frame_start),
            .step     (take_step),
            .dec      (decisions[gs]),
            .cand0    (surv_q[P0]),
            .cand1    (surv_q[P1]),
            .surv_q   (surv_q[gs]),
            .surv_next(surv_next[gs])
         );
      end
   endgenerate

   re_step_counter #(.FRAME_BITS(FRAME_BITS)) u_count (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(frame_start),
      .step (take_step),
      .last (at_last)
   );

   re_word_select #(
      .NUM_STATES(NUM_STATES),
      .STATE_BITS(STATE_BITS),
      .WIDTH     (FRAME_BITS)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .emit      (emit),
      .best      (best_state),
      .surv_next (surv_next),
      .word_valid(word_valid),
      .word_out  (word_out)
   );

endmodule

// File: rtl/re_survivor_sva.sv
module re_survivor_sva #(
   parameter int unsigned CONSTRAINT_LEN = 3,
   parameter int unsigned FRAME_BITS     = 8,
   localparam int unsigned STATE_BITS    = CONSTRAINT_LEN - 1,
   localparam int unsigned NUM_STATES    = 1 << STATE_BITS
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  frame_start,
   input logic                  step_valid,
   input logic [NUM_STATES-1:0] decisions,
   input logic [STATE_BITS-1:0] best_state,
   input logic                  word_valid,
   input logic [FRAME_BITS-1:0] word_out
);
   // Independent count of accepted steps within the current word.
   int unsigned seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 0;
      end else if (frame_start) begin
         seen_q <= 0;
      end else if (step_valid) begin
         seen_q <= (seen_q == FRAME_BITS - 1) ? 0 : seen_q + 1;
      end
   end

   // R5: strobe lasts one cycle
   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R5, R2, R7: strobe only after the eighth accepted step
   assert_strobe_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> ($past(step_valid) && !$past(frame_start)
                      && $past(seen_q) == FRAME_BITS - 1));

   // R8: word holds between strobes
   assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> $stable(word_out));

   // R3, R4: newest bit of the word is the entry bit of the best state
   assert_newest_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> word_out[0] == $past(best_state[STATE_BITS-1]));

   // R4: previous bit equals the entry bit of the predecessor
   assert_prev_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> word_out[1] == $past(best_state[STATE_BITS-2]));

   // R7: a clear cycle never yields a strobe next cycle
   assert_clear_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !word_valid);

endmodule

bind re_survivor_unit re_survivor_sva #(
   .CONSTRAINT_LEN(CONSTRAINT_LEN),
   .FRAME_BITS    (FRAME_BITS)
) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_start(frame_start),
   .step_valid (step_valid),
   .decisions  (decisions),
   .best_state (best_state),
   .word_valid (word_valid),
   .word_out   (word_out)
);

// File: tb/tb_re_survivor_unit.sv
`timescale 1ns/1ps
module tb_re_survivor_unit;
   localparam int NS = 4;
   localparam int FB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          step_valid = 1'b0;
   logic [NS-1:0] decisions = '0;
   logic [1:0]    best_state = '0;
   logic          word_valid;
   logic [FB-1:0] word_out;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   // reference state
   int surv [NS];
   int steps = 0;
   bit exp_valid = 0;
   int exp_word = 0;

   always #2 clk = ~clk;

   re_survivor_unit dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .step_valid(step_valid), .decisions(decisions),
      .best_state(best_state), .word_valid(word_valid), .word_out(word_out)
   );

   task automatic check(input string req);
      compared++;
      if (word_valid !== exp_valid) begin
         mismatched++;
         $display("FAIL %s word_valid actual=%0b expected=%0b t=%0t", req, word_valid, exp_valid, $time);
      end
      compared++;
      if (word_out !== FB'(exp_word)) begin
         mismatched++;
         $display("FAIL %s word_out actual=%02h expected=%02h t=%0t", req, word_out, FB'(exp_word), $time);
      end
   endtask

   // One cycle: drive at falling edge, model at rising edge, compare at next falling edge.
   task automatic cyc(input bit fs, input bit sv, input int dec, input int best, input string req);
      int nxt [NS];
      frame_start = fs; step_valid = sv;
      decisions = NS'(dec); best_state = 2'(best);
      @(posedge clk);
      exp_valid = 0;
      if (fs) begin
         foreach (surv[s]) surv[s] = 0;
         steps = 0;
      end else if (sv) begin
         for (int s = 0; s < NS; s++) begin
            int p;
            p = ((s % 2) * 2) + ((dec >> s) & 1);
            nxt[s] = ((surv[p] * 2) + (s / 2)) % 256;
         end
         foreach (surv[s]) surv[s] = nxt[s];
         steps++;
         if (steps == FB) begin
            steps = 0;
            exp_valid = 1;
            exp_word = surv[best];
         end
      end
      @(negedge clk);
      check(req);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      foreach (surv[s]) surv[s] = 0;
      @(negedge clk); check("R1");
      @(negedge clk); check("R1");
      rst_n = 1'b1;
      @(negedge clk); check("R1");

      // R3: all-ones decisions, best state 3 keeps appending 1
      cyc(1, 0, 0, 0, "R2");
      for (int i = 0; i < FB; i++) cyc(0, 1, 4'hF, 3, "R3");
      compared++;
      if (word_out !== 8'hFF) begin
         mismatched++;
         $display("FAIL R3 actual=%02h expected=ff", word_out);
      end

      // R4: state 2 entered with decision 0 from state 0 -> only last bit set path
      cyc(1, 0, 0, 0, "R2");
      for (int i = 0; i < FB; i++) cyc(0, 1, 4'h0, (i == FB - 1) ? 2 : 0, "R4");
      compared++;
      if (word_out !== 8'h01) begin
         mismatched++;
         $display("FAIL R4 actual=%02h expected=01", word_out);
      end
      cyc(0, 0, 0, 0, "R8");

      // R3, R5: random steps in full frames
      cyc(1, 0, 0, 0, "R2");
      for (int i = 0; i < 5 * FB; i++)
         cyc(0, 1, $urandom_range(0, 15), $urandom_range(0, 3), "R5");

      // R6: gaps with junk inputs
      for (int i = 0; i < 6 * FB; i++) begin
         bit sv;
         sv = ($urandom_range(0, 2) == 0);
         cyc(0, sv, $urandom_range(0, 15), $urandom_range(0, 3), sv ? "R9" : "R6");
      end

      // R2: restart mid-frame
      for (int i = 0; i < 3; i++) cyc(0, 1, $urandom_range(0, 15), 1, "R3");
      cyc(1, 0, 0, 0, "R2");
      for (int i = 0; i < FB; i++) cyc(0, 1, $urandom_range(0, 15), $urandom_range(0, 3), "R2");

      // R7: clear and step together
      for (int i = 0; i < 5; i++) cyc(0, 1, $urandom_range(0, 15), 2, "R7");
      cyc(1, 1, 4'hF, 3, "R7");
      for (int i = 0; i < FB + 2; i++) cyc(0, 1, $urandom_range(0, 15), $urandom_range(0, 3), "R7");

      // R8, R9: long stream with idles
      for (int i = 0; i < 400; i++)
         cyc(0, $urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 3), "R8");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule